// File: doc/BRIEF.md
# Shadow RAM Memory Decoder

This block sorts each CPU memory cycle of a PC chipset into one of two destinations: system DRAM or the ISA/ROM path. A cycle is presented as a 32-bit address, a write flag and a one-cycle strobe. One clock later the block drives registered selects for DRAM and for ISA, a ROM chip select, a flag that steers read data from the ROM data bus, and the ISA memory read or write command.

Software sets up the routing through a small write-only register port. The ROM windows at C0000–FFFFF can be copied into RAM and then run from it. Each window has a pair of enables, one for reads and one for writes, so it can be loaded, write-protected or fully moved into DRAM. Each of the two video windows has a single enable bit. A second set of enable bits covers E0000–FFFFF in 32KB granules and is OR'd into the normal pair, so a flash image can be run from RAM while parts of the ROM stay visible.

The top 1MB of the 4GB space always decodes to ROM, so the boot fetch works whatever the configuration holds. Address bits 30:28 are not looked at. In the lower 2GB, memory therefore repeats every 256MB.

Top module: `shadow_mem_decoder`

## Requirements
- R1: After reset every configuration field is zero. Every cycle then goes to ISA with no ROM chip select, including cycles to C0000–FFFFF and to conventional memory.
- R2: Register 0 holds eight 16KB windows covering C0000–DFFFF. Window k = (addr-C0000)/16KB. Bit 2k is its read enable and bit 2k+1 its write enable. A read goes to DRAM when the read enable is 1, and a write goes to DRAM when the write enable is 1. Otherwise the cycle goes to ISA.
- R3: Register 1 holds the E and F 64KB windows. Bits 1:0 are read/write for E0000 and bits 3:2 are read/write for F0000. They route cycles as in R2.
- R4: Register 2 bit 0 enables A0000–AFFFF and bit 1 enables B0000–BFFFF. A set bit sends both reads and writes of that window to DRAM.
- R5: Register 3 bits 3:0 are flash-shadow bits for the 32KB granules at E0000, E8000, F0000 and F8000. A set bit forces both the read and the write enable of its granule to 1.
- R6: A read with A31=1 and A27:20 all ones asserts ISA select, ROM chip select, the read command and ROM data steering, and never DRAM select. This holds whatever the configuration registers contain.
- R7: A write to that top 1MB asserts ISA select, ROM chip select and the write command, and does not assert steering. This holds even when register 4 is zero.
- R8: Address bits 30:28 have no effect on any output. With A31=0 the decode uses only A27:0, so memory aliases every 256MB.
- R9: Register 5 holds the top of DRAM in 1MB units. With A31=0, a cycle may go to DRAM only if A27:20 is below this value. Otherwise it goes to ISA.
- R10: Any other cycle with A31=1 goes to ISA with no ROM chip select.
- R11: Register 4 bit n enables ROM chip select for the 64KB window C0000+n·64KB. An ISA-routed cycle in an enabled window asserts ROM chip select, and steering as well when the cycle is a read.
- R12: Outputs are registered one clock after the strobe.
  - An ISA cycle drives the read command for a read or the write command for a write.
  - A DRAM cycle drives DRAM select only.
  - A clock without a strobe drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register number |
| cfg_wdata_i | input | 16 | Configuration write data |
| cyc_valid_i | input | 1 | Memory cycle strobe |
| cyc_addr_i | input | 32 | Memory cycle address |
| cyc_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| dram_sel_o | output | 1 | Cycle claimed by DRAM |
| isa_sel_o | output | 1 | Cycle sent to the ISA/ROM path |
| rom_cs_o | output | 1 | ROM chip select |
| rom_steer_o | output | 1 | Steer read data from the ROM data bus |
| memr_o | output | 1 | ISA memory read command |
| memw_o | output | 1 | ISA memory write command |

## Verification
The assertions assume that the strobe, the write flag and the address are known values at every sampled clock edge. They also assume the strobe is held low while reset is asserted, because the output checks refer to the inputs of the previous edge. The bench drives every input at the falling edge and keeps the strobe low throughout reset. It writes configuration only on clocks that carry no memory cycle, so each expected value depends on one settled configuration.

// File: rtl/smd_pkg.sv
package smd_pkg;
  localparam int ADDR_W = 32;
  localparam int MB_W   = 8;   // A27:20, 1MB units within a 256MB block

  typedef enum logic [2:0] {
    RG_PLAIN,   // conventional or above 1MB in the low half
    RG_VIDEO,   // A0000-BFFFF
    RG_LOSH,    // C0000-DFFFF
    RG_HISH,    // E0000-FFFFF
    RG_UPPER,   // A31 set, not top 1MB
    RG_TOPROM   // fixed boot ROM window
  } region_e;

  typedef struct packed {
    logic dram;
    logic isa;
    logic rom_cs;
    logic rom_steer;
    logic memr;
    logic memw;
  } route_t;
endpackage

// File: rtl/smd_cfg_regs.sv
module smd_cfg_regs #(
  parameter int CFG_AW   = 3,
  parameter int CFG_DW   = 16,
  parameter int LO_SEGS  = 8,
  parameter int HI_SEGS  = 2,
  parameter int FL_GRAN  = 4,
  parameter int VID_SEGS = 2,
  parameter int ROM_SEGS = 4,
  parameter int TOM_W    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [CFG_AW-1:0]     sel_i,
  input  logic [CFG_DW-1:0]     wdata_i,
  output logic [2*LO_SEGS-1:0]  seg_lo_o,
  output logic [2*HI_SEGS-1:0]  seg_hi_o,
  output logic [VID_SEGS-1:0]   vid_o,
  output logic [FL_GRAN-1:0]    flash_o,
  output logic [ROM_SEGS-1:0]   rom_en_o,
  output logic [TOM_W-1:0]      tom_o
);
  localparam logic [CFG_AW-1:0] SEL_LO   = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] SEL_HI   = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] SEL_VID  = CFG_AW'(2);
  localparam logic [CFG_AW-1:0] SEL_FL   = CFG_AW'(3);
  localparam logic [CFG_AW-1:0] SEL_ROM  = CFG_AW'(4);
  localparam logic [CFG_AW-1:0] SEL_TOM  = CFG_AW'(5);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_lo_o <= '0;
      seg_hi_o <= '0;
      vid_o    <= '0;
      flash_o  <= '0;
      rom_en_o <= '0;
      tom_o    <= '0;
    end else if (we_i) begin
      case (sel_i)
        SEL_LO:  seg_lo_o <= wdata_i[2*LO_SEGS-1:0];
        SEL_HI:  seg_hi_o <= wdata_i[2*HI_SEGS-1:0];
        SEL_VID: vid_o    <= wdata_i[VID_SEGS-1:0];
        SEL_FL:  flash_o  <= wdata_i[FL_GRAN-1:0];
        SEL_ROM: rom_en_o <= wdata_i[ROM_SEGS-1:0];
        SEL_TOM: tom_o    <= wdata_i[TOM_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smd_region_decode.sv
module smd_region_decode
  import smd_pkg::*;
#(
  parameter int LO_SEGS  = 8,
  parameter int FL_GRAN  = 4,
  parameter int VID_SEGS = 2,
  parameter int ROM_SEGS = 4,
  localparam int LO_IW   = $clog2(LO_SEGS),
  localparam int FL_IW   = $clog2(FL_GRAN),
  localparam int VID_IW  = $clog2(VID_SEGS),
  localparam int ROM_IW  = $clog2(ROM_SEGS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [LO_IW-1:0]  lo_idx_o,
  output logic [FL_IW-1:0]  fl_idx_o,
  output logic [VID_IW-1:0] vid_idx_o,
  output logic [ROM_IW-1:0] rom_idx_o,
  output logic [MB_W-1:0]   mb_o
);
  // each window pair (A/B, C/D, E/F) spans 128KB, offset is A16:0
  localparam int PAIR_W = 17;
  localparam int LO_SH  = PAIR_W - LO_IW;
  localparam int FL_SH  = PAIR_W - FL_IW;
  localparam int VID_SH = PAIR_W - VID_IW;
  localparam int ROM_SH = 16;

  logic [PAIR_W-1:0] off;
  logic [3:0]        seg64;
  logic              unused_addr_bits;

  assign off   = addr_i[PAIR_W-1:0];
  assign seg64 = addr_i[19:16];
  assign mb_o  = addr_i[27:20];
  assign unused_addr_bits = ^addr_i[30:28];

  assign lo_idx_o  = LO_IW'(off >> LO_SH);
  assign fl_idx_o  = FL_IW'(off >> FL_SH);
  assign vid_idx_o = VID_IW'(off >> VID_SH);
  assign rom_idx_o = ROM_IW'(addr_i[19:0] >> ROM_SH);

  always_comb begin
    region_o = RG_PLAIN;
    if (addr_i[31]) begin
      region_o = (&mb_o) ? RG_TOPROM : RG_UPPER;
    end else if (mb_o == '0) begin
      case (seg64)
        4'hA, 4'hB: region_o = RG_VIDEO;
        4'hC, 4'hD: region_o = RG_LOSH;
        4'hE, 4'hF: region_o = RG_HISH;
        default:    region_o = RG_PLAIN;
      endcase
    end
  end
endmodule

// File: rtl/smd_route.sv
module smd_route
  import smd_pkg::*;
#(
  parameter int LO_SEGS  = 8,
  parameter int HI_SEGS  = 2,
  parameter int FL_GRAN  = 4,
  parameter int VID_SEGS = 2,
  parameter int ROM_SEGS = 4,
  localparam int LO_IW   = $clog2(LO_SEGS),
  localparam int FL_IW   = $clog2(FL_GRAN),
  localparam int VID_IW  = $clog2(VID_SEGS),
  localparam int ROM_IW  = $clog2(ROM_SEGS),
  localparam int G_PER_H = FL_GRAN / HI_SEGS
) (
  input  logic                 valid_i,
  input  logic                 write_i,
  input  region_e              region_i,
  input  logic [LO_IW-1:0]     lo_idx_i,
  input  logic [FL_IW-1:0]     fl_idx_i,
  input  logic [VID_IW-1:0]    vid_idx_i,
  input  logic [ROM_IW-1:0]    rom_idx_i,
  input  logic [MB_W-1:0]      mb_i,
  input  logic [2*LO_SEGS-1:0] seg_lo_i,
  input  logic [2*HI_SEGS-1:0] seg_hi_i,
  input  logic [VID_SEGS-1:0]  vid_i,
  input  logic [FL_GRAN-1:0]   flash_i,
  input  logic [ROM_SEGS-1:0]  rom_en_i,
  input  logic [MB_W-1:0]      tom_i,
  output route_t               route_o
);
  logic [LO_SEGS-1:0] lo_rd, lo_wr;
  logic [FL_GRAN-1:0] hi_rd, hi_wr;
  logic               win_en, to_dram, rom_win;

  for (genvar k = 0; k < LO_SEGS; k++) begin : g_lo
    assign lo_rd[k] = seg_lo_i[2*k];
    assign lo_wr[k] = seg_lo_i[2*k+1];
  end

  // flash granules widen the 64KB pair into per-32KB enables
  for (genvar g = 0; g < FL_GRAN; g++) begin : g_gran
    localparam int H = g / G_PER_H;
    assign hi_rd[g] = seg_hi_i[2*H]   | flash_i[g];
    assign hi_wr[g] = seg_hi_i[2*H+1] | flash_i[g];
  end

  always_comb begin
    case (region_i)
      RG_VIDEO: win_en = vid_i[vid_idx_i];
      RG_LOSH:  win_en = write_i ? lo_wr[lo_idx_i] : lo_rd[lo_idx_i];
      RG_HISH:  win_en = write_i ? hi_wr[fl_idx_i] : hi_rd[fl_idx_i];
      RG_PLAIN: win_en = 1'b1;
      default:  win_en = 1'b0;
    endcase
  end

  assign to_dram = win_en && (mb_i < tom_i);
  assign rom_win = ((region_i == RG_LOSH) || (region_i == RG_HISH)) && rom_en_i[rom_idx_i];

  always_comb begin
    route_o = '0;
    if (valid_i) begin
      if (region_i == RG_TOPROM) begin
        route_o.isa       = 1'b1;
        route_o.rom_cs    = 1'b1;
        route_o.rom_steer = !write_i;
        route_o.memr      = !write_i;
        route_o.memw      = write_i;
      end else if (to_dram) begin
        route_o.dram = 1'b1;
      end else begin
        route_o.isa       = 1'b1;
        route_o.rom_cs    = rom_win;
        route_o.rom_steer = rom_win && !write_i;
        route_o.memr      = !write_i;
        route_o.memw      = write_i;
      end
    end
  end
endmodule

// File: rtl/shadow_mem_decoder.sv
module shadow_mem_decoder
  import smd_pkg::*;
#(
  parameter int CFG_AW   = 3,
  parameter int CFG_DW   = 16,
  parameter int LO_SEGS  = 8,
  parameter int HI_SEGS  = 2,
  parameter int FL_GRAN  = 4,
  parameter int VID_SEGS = 2,
  parameter int ROM_SEGS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_sel_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              cyc_valid_i,
  input  logic [31:0]       cyc_addr_i,
  input  logic              cyc_write_i,
  output logic              dram_sel_o,
  output logic              isa_sel_o,
  output logic              rom_cs_o,
  output logic              rom_steer_o,
  output logic              memr_o,
  output logic              memw_o
);
  localparam int LO_IW  = $clog2(LO_SEGS);
  localparam int FL_IW  = $clog2(FL_GRAN);
  localparam int VID_IW = $clog2(VID_SEGS);
  localparam int ROM_IW = $clog2(ROM_SEGS);

  logic [2*LO_SEGS-1:0] seg_lo;
  logic [2*HI_SEGS-1:0] seg_hi;
  logic [VID_SEGS-1:0]  vid;
  logic [FL_GRAN-1:0]   flash;
  logic [ROM_SEGS-1:0]  rom_en;
  logic [MB_W-1:0]      tom;

  region_e           region;
  logic [LO_IW-1:0]  lo_idx;
  logic [FL_IW-1:0]  fl_idx;
  logic [VID_IW-1:0] vid_idx;
  logic [ROM_IW-1:0] rom_idx;
  logic [MB_W-1:0]   mb;
  route_t            route_d, route_q;

  smd_cfg_regs #(
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .LO_SEGS(LO_SEGS), .HI_SEGS(HI_SEGS),
    .FL_GRAN(FL_GRAN), .VID_SEGS(VID_SEGS), .ROM_SEGS(ROM_SEGS), .TOM_W(MB_W)
  ) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .seg_lo_o(seg_lo), .seg_hi_o(seg_hi), .vid_o(vid),
    .flash_o(flash), .rom_en_o(rom_en), .tom_o(tom)
  );

  smd_region_decode #(
    .LO_SEGS(LO_SEGS), .FL_GRAN(FL_GRAN), .VID_SEGS(VID_SEGS), .ROM_SEGS(ROM_SEGS)
  ) i_dec (
    .addr_i(cyc_addr_i), .region_o(region), .lo_idx_o(lo_idx),
    .fl_idx_o(fl_idx), .vid_idx_o(vid_idx), .rom_idx_o(rom_idx), .mb_o(mb)
  );

  smd_route #(
    .LO_SEGS(LO_SEGS), .HI_SEGS(HI_SEGS), .FL_GRAN(FL_GRAN),
    .VID_SEGS(VID_SEGS), .ROM_SEGS(ROM_SEGS)
  ) i_route (
    .valid_i(cyc_valid_i), .write_i(cyc_write_i), .region_i(region),
    .lo_idx_i(lo_idx), .fl_idx_i(fl_idx), .vid_idx_i(vid_idx),
    .rom_idx_i(rom_idx), .mb_i(mb),
    .seg_lo_i(seg_lo), .seg_hi_i(seg_hi), .vid_i(vid), .flash_i(flash),
    .rom_en_i(rom_en), .tom_i(tom), .route_o(route_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) route_q <= '0;
    else         route_q <= route_d;
  end

  assign dram_sel_o  = route_q.dram;
  assign isa_sel_o   = route_q.isa;
  assign rom_cs_o    = route_q.rom_cs;
  assign rom_steer_o = route_q.rom_steer;
  assign memr_o      = route_q.memr;
  assign memw_o      = route_q.memw;
endmodule

// File: rtl/smd_checker.sv
module smd_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cyc_valid_i,
  input logic [31:0] cyc_addr_i,
  input logic        cyc_write_i,
  input logic        dram_sel_o,
  input logic        isa_sel_o,
  input logic        rom_cs_o,
  input logic        rom_steer_o,
  input logic        memr_o,
  input logic        memw_o
);
  logic armed;
  logic top_hit, upper_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assign top_hit   = cyc_valid_i && cyc_addr_i[31] && (&cyc_addr_i[27:20]);
  assign upper_hit = cyc_valid_i && cyc_addr_i[31] && !(&cyc_addr_i[27:20]);

  a_r6_top_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(top_hit && !cyc_write_i)
      |-> rom_cs_o && rom_steer_o && memr_o && !memw_o && !dram_sel_o);

  a_r7_top_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(top_hit && cyc_write_i)
      |-> rom_cs_o && memw_o && !rom_steer_o && !memr_o && !dram_sel_o);

  a_r10_upper_isa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(upper_hit) |-> isa_sel_o && !dram_sel_o && !rom_cs_o);

  a_r12_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dram_sel_o, isa_sel_o}) && !(memr_o && memw_o));

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(cyc_valid_i)
      |-> !(dram_sel_o || isa_sel_o || rom_cs_o || rom_steer_o || memr_o || memw_o));

  a_r11_steer_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_steer_o |-> rom_cs_o && memr_o && isa_sel_o);
endmodule

bind shadow_mem_decoder smd_checker i_smd_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cyc_valid_i(cyc_valid_i),
  .cyc_addr_i(cyc_addr_i), .cyc_write_i(cyc_write_i),
  .dram_sel_o(dram_sel_o), .isa_sel_o(isa_sel_o), .rom_cs_o(rom_cs_o),
  .rom_steer_o(rom_steer_o), .memr_o(memr_o), .memw_o(memw_o)
);

// File: tb/test_shadow_mem_decoder.sv
module test_shadow_mem_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        cyc_valid_i = 1'b0;
  logic [31:0] cyc_addr_i = '0;
  logic        cyc_write_i = 1'b0;
  logic dram_sel_o, isa_sel_o, rom_cs_o, rom_steer_o, memr_o, memw_o;

  int checks = 0;
  int failures = 0;

  // behavioural configuration model
  bit lo_rd[8], lo_wr[8], hi_rd[2], hi_wr[2], fl[4], vid[2], rom[4];
  int tom = 0;

  logic [5:0] pend_exp = '0;
  string      pend_tag = "R1";
  bit         done = 0;

  shadow_mem_decoder i_shadow_mem_decoder (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // {dram, isa, rom_cs, steer, memr, memw}
  function automatic logic [5:0] model(logic [31:0] a, logic w);
    int unsigned off = a & 32'h0FFF_FFFF;
    int unsigned mb  = off / 32'h10_0000;
    int unsigned lo  = off % 32'h10_0000;
    bit to_d = 1;
    bit cs = 0;
    if (a[31] && mb == 255) return w ? 6'b011001 : 6'b011110;
    if (a[31]) return w ? 6'b010001 : 6'b010010;
    if (mb == 0) begin
      if (lo >= 32'hA0000 && lo < 32'hC0000)
        to_d = vid[(lo - 32'hA0000) / 32'h10000];
      else if (lo >= 32'hC0000 && lo < 32'hE0000) begin
        int k = int'((lo - 32'hC0000) / 32'h4000);
        to_d = w ? lo_wr[k] : lo_rd[k];
      end else if (lo >= 32'hE0000) begin
        int g = int'((lo - 32'hE0000) / 32'h8000);
        to_d = (w ? hi_wr[g/2] : hi_rd[g/2]) | fl[g];
      end
    end
    if (int'(mb) >= tom) to_d = 0;
    if (to_d) return 6'b100000;
    if (mb == 0 && lo >= 32'hC0000) cs = rom[(lo - 32'hC0000) / 32'h10000];
    return {1'b0, 1'b1, cs, cs & !w, !w, w};
  endfunction

  task automatic compare_pending();
    logic [5:0] act = {dram_sel_o, isa_sel_o, rom_cs_o, rom_steer_o, memr_o, memw_o};
    checks++;
    if (act !== pend_exp) begin
      failures++;
      $display("FAIL %s: outputs %b expected %b", pend_tag, act, pend_exp);
    end
  endtask

  // one clock: check last clock's result, then drive this clock's inputs
  task automatic step(bit v, logic [31:0] a, bit w, string tag);
    @(negedge clk_i);
    compare_pending();
    cfg_we_i    = 1'b0;
    cyc_valid_i = v;
    cyc_addr_i  = a;
    cyc_write_i = w;
    pend_exp    = v ? model(a, w) : 6'b0;
    pend_tag    = tag;
  endtask

  task automatic cfg(logic [2:0] sel, logic [15:0] d);
    @(negedge clk_i);
    compare_pending();
    cyc_valid_i = 1'b0;
    cfg_we_i    = 1'b1;
    cfg_sel_i   = sel;
    cfg_wdata_i = d;
    pend_exp    = '0;
    pend_tag    = "R12";
    case (sel)
      3'd0: for (int k = 0; k < 8; k++) begin lo_rd[k] = d[2*k]; lo_wr[k] = d[2*k+1]; end
      3'd1: for (int k = 0; k < 2; k++) begin hi_rd[k] = d[2*k]; hi_wr[k] = d[2*k+1]; end
      3'd2: for (int k = 0; k < 2; k++) vid[k] = d[k];
      3'd3: for (int k = 0; k < 4; k++) fl[k] = d[k];
      3'd4: for (int k = 0; k < 4; k++) rom[k] = d[k];
      3'd5: tom = int'(d[7:0]);
      default: ;
    endcase
  endtask

  task automatic expect_now(logic [5:0] e, string tag);
    // direct check of a known constant against the model's view
    checks++;
    if (pend_exp !== e) begin
      failures++;
      $display("FAIL %s: model %b expected %b", tag, pend_exp, e);
    end
  endtask

  task automatic rw_pair(logic [31:0] a, string tag);
    step(1, a, 0, tag);
    step(1, a, 1, tag);
  endtask

  function automatic logic [31:0] rand_addr();
    logic [31:0] a = $urandom;
    int sel = $urandom_range(0, 9);
    if (sel < 5) begin
      a[31] = 1'b0;
      a[27:20] = '0;
      a[19:16] = 4'(10 + $urandom_range(0, 5));
    end else if (sel == 5) begin
      a[31] = 1'b1;
      a[27:20] = 8'hFF;
    end else if (sel == 6) begin
      a[31] = 1'b0;
      a[27:20] = 8'($urandom_range(0, 40));
    end
    return a;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state, all to ISA with no ROM select
    checks++;
    if ({dram_sel_o, isa_sel_o, rom_cs_o, rom_steer_o, memr_o, memw_o} !== 6'b0) begin
      failures++;
      $display("FAIL R1: reset outputs %b expected 000000",
               {dram_sel_o, isa_sel_o, rom_cs_o, rom_steer_o, memr_o, memw_o});
    end
    rw_pair(32'h000C_4000, "R1");
    step(1, 32'h000C_4000, 0, "R1");
    expect_now(6'b010010, "R1");
    rw_pair(32'h000F_8000, "R1");
    rw_pair(32'h0000_1000, "R1");
    step(0, 32'h0000_1000, 0, "R12");

    // R9: top of DRAM at 16MB
    cfg(3'd5, 16'd16);
    step(1, 32'h0000_1000, 0, "R9");
    expect_now(6'b100000, "R9");
    rw_pair(32'h00F0_0000, "R9");
    step(1, 32'h0100_0000, 0, "R9");
    expect_now(6'b010010, "R9");
    rw_pair(32'h0100_0004, "R9");

    // R2: four codes over the C/D windows
    cfg(3'd0, 16'b11_01_10_00_11_01_10_00);
    for (int k = 0; k < 8; k++) rw_pair(32'h000C_0000 + k * 32'h4000 + 32'h10, "R2");
    step(1, 32'h000C_4000, 1, "R2");
    expect_now(6'b100000, "R2");

    // R3: E and F windows
    cfg(3'd1, 16'b10_01);
    rw_pair(32'h000E_0100, "R3");
    rw_pair(32'h000F_F000, "R3");
    step(1, 32'h000E_0000, 0, "R3");
    expect_now(6'b100000, "R3");

    // R4: video windows
    cfg(3'd2, 16'b01);
    rw_pair(32'h000A_8000, "R4");
    rw_pair(32'h000B_8000, "R4");
    step(1, 32'h000B_0000, 1, "R4");
    expect_now(6'b010001, "R4");

    // R11: ROM chip select on ISA-routed windows
    cfg(3'd4, 16'b1011);
    for (int k = 0; k < 4; k++) rw_pair(32'h000C_0000 + k * 32'h10000 + 32'h8000, "R11");
    step(1, 32'h000C_0000, 0, "R11");
    expect_now(6'b011110, "R11");

    // R5: flash granules OR'd in
    cfg(3'd1, 16'b00_00);
    cfg(3'd3, 16'b0110);
    for (int g = 0; g < 4; g++) rw_pair(32'h000E_0000 + g * 32'h8000 + 32'h20, "R5");
    step(1, 32'h000E_8000, 1, "R5");
    expect_now(6'b100000, "R5");

    // R6 / R7: top 1MB with everything set and with everything clear
    cfg(3'd0, 16'hFFFF);
    cfg(3'd1, 16'h000F);
    cfg(3'd5, 16'h00FF);
    step(1, 32'hFFFF_FFF0, 0, "R6");
    expect_now(6'b011110, "R6");
    step(1, 32'h8FF0_0000, 0, "R6");
    step(1, 32'hFFF1_2344, 1, "R7");
    expect_now(6'b011001, "R7");
    cfg(3'd4, 16'h0000);
    step(1, 32'hFFF0_0000, 1, "R7");
    step(1, 32'hFFFF_0000, 0, "R6");

    // R10: A31 set, not top
    step(1, 32'h8000_1000, 0, "R10");
    expect_now(6'b010010, "R10");
    rw_pair(32'h800F_0000, "R10");

    // R8: A30:28 ignored, 256MB aliasing
    cfg(3'd5, 16'd8);
    for (int h = 0; h < 8; h++) begin
      rw_pair({1'b0, 3'(h), 28'h000_1000}, "R8");
      rw_pair({1'b0, 3'(h), 28'h080_0000}, "R8");
      rw_pair({1'b1, 3'(h), 28'hFF0_0000}, "R8");
    end
    step(1, 32'h7000_1000, 0, "R8");
    expect_now(6'b100000, "R8");

    // mixed sweep
    for (int n = 0; n < 3000; n++) begin
      if (n % 60 == 0) begin
        cfg(3'($urandom_range(0, 5)), 16'($urandom));
        cfg(3'd5, 16'($urandom_range(0, 32)));
      end
      step($urandom_range(0, 3) != 0, rand_addr(), 1'($urandom), "R12");
    end
    step(0, 32'h0, 0, "R12");
    step(0, 32'h0, 0, "R12");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule